// File: doc/BRIEF.md
# Streaming Multi-Word Program Sequencer

This block is the burst-programming engine of a one-time-programmable word memory, with the memory array included as a behavioural model. A host unlocks the engine with three setup bus writes. It then streams data words. Only the first write of a phase carries a usable address. Every later write names no location. The engine steps its own word pointer. It looks only at the upper address field to learn whether the stream goes on or has ended.

Once the program pass is done, the host sends the same stream a second time. Each word of this pass is compared with the array. Where they differ, the engine programs the cell again, up to a bounded number of attempts. While the sequence runs, every bus read returns a status word instead of array data. This status word reports:

- a ready/busy flag,
- a toggle that flips on each status read,
- an error flag,
- a program-voltage-loss flag.

Top module: `burst_prog_seq`

## Requirements
- R1: Setup is three writes, decoded on address bits [10:0] and data bits [7:0] only: 0x555/0xAA, then 0x2AA/0x55, then 0x555/0xC7. Any other write, or a write with `vpp_ok` low, returns the block to read mode. After a complete setup, status reads show bit 7 = 1 and bit 0 = 0.
- R2: Outside a sequence, a read returns the array word at index `addr[IDX_W-1:0]` one cycle after `rd_en`. Every word of the array reads 0xFFFF after reset.
- R3: The first write of a phase latches the start address and the first word. Each later write whose bits [21:17] equal the start's handles the next consecutive index, and its bits [16:0] are ignored.
- R4: A write in which any of bits [21:17] differs from the start address ends the phase, and its data is not written anywhere. A phase of n words therefore takes n+1 writes.
- R5: Programming can only clear bits: the stored word becomes the old word AND the written word.
- R6: After each accepted word, status bit 0 reads 1 while the word is handled. In the program pass this lasts PROG_CYC cycles. Writes that arrive while bit 0 is 1 are dropped.
- R7: In the verify pass, a word equal to the stored word is accepted. A word that differs causes the cell to be programmed again. A verify pass with no failure returns the block to read mode, and array reads then resume.
- R8: If, after MAX_RETRY reprogram attempts, the stored word still differs from the resent word, the sequence stops in a failed state. In that state, status bit 5 = 1 and bit 0 = 0.
- R9: If `vpp_ok` drops during a sequence, the sequence aborts with status bits 4 and 5 set, and the word in progress is not written.
- R10: In the failed state, only a write with data[7:0] = 0xF0 while `vpp_ok` is high is honoured. It clears the error bits and returns the block to read mode. All other writes in the failed state are ignored.
- R11: Status bit 6 starts at 0 when a sequence begins. It flips after every status read, including reads made in the failed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, data valid next cycle |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| vpp_ok | input | 1 | Program voltage is in range |
| rdata | output | DATA_W | Array word or status word |

## Verification
The bench aims a write at the busy window right after a word is accepted. A design that fails to drop it would AND zero into the first word. The program pass ends with a final write that carries zero data and differs only in address bit 19. A design that compares too few upper bits would treat it as a continuation and clear the next word.

The verify pass resends one word with fewer ones than the stored value, which must be reprogrammed and then accepted. A separate sequence resends a word that asks to set a bit back to 1. That must end in the failed state with a toggle that keeps flipping, not a quiet return to read mode. A one-cycle drop of `vpp_ok` during a busy word checks that the voltage flag is raised and that the interrupted word is never written.

// File: rtl/burst_prog_seq.sv
module burst_prog_seq #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 8,
  parameter int MARK_LO   = 17,
  parameter int CMD_AW    = 11,
  parameter int PROG_CYC  = 4,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vpp_ok,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MARK_W = ADDR_W - MARK_LO;
  localparam int CNT_W  = $clog2(PROG_CYC + 1);
  localparam int TRY_W  = $clog2(MAX_RETRY + 1);

  localparam logic [CMD_AW-1:0] U1_A = 'h555;
  localparam logic [CMD_AW-1:0] U2_A = 'h2AA;
  localparam logic [7:0] U1_D = 8'hAA, U2_D = 8'h55, GO_D = 8'hC7, CLR_D = 8'hF0;

  typedef enum logic [3:0] {
    S_IDLE, S_UNLK1, S_UNLK2, S_P_FIRST, S_P_BUSY, S_P_RUN,
    S_V_FIRST, S_V_BUSY, S_V_RUN, S_FAIL
  } st_t;

  st_t               st;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [MARK_W-1:0] mark_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wbuf;
  logic [CNT_W-1:0]  cnt;
  logic [TRY_W-1:0]  tries;
  logic              err_q, verr_q, tgl_q;

  logic in_op, run_st, fail_st, busy, cont;
  logic [DATA_W-1:0] status_w;
  logic unused_bits;

  assign in_op   = (st != S_IDLE) && (st != S_UNLK1) && (st != S_UNLK2);
  assign run_st  = (st == S_P_RUN) || (st == S_V_RUN);
  assign fail_st = (st == S_FAIL);
  assign busy    = (st == S_P_BUSY) || (st == S_V_BUSY);
  assign cont    = addr[ADDR_W-1:MARK_LO] == mark_q;
  assign status_w = DATA_W'({1'b1, tgl_q, err_q, verr_q, 3'b000, busy});
  assign unused_bits = ^addr[MARK_LO-1:CMD_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mark_q <= '0;
      idx_q  <= '0;
      wbuf   <= '0;
      cnt    <= '0;
      tries  <= '0;
      err_q  <= 1'b0;
      verr_q <= 1'b0;
      tgl_q  <= 1'b0;
      rdata  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (rd_en) begin
        if (in_op) begin
          rdata <= status_w;
          tgl_q <= ~tgl_q;
        end else begin
          rdata <= mem[addr[IDX_W-1:0]];
        end
      end

      if (in_op && !fail_st && !vpp_ok) begin
        st     <= S_FAIL;
        err_q  <= 1'b1;
        verr_q <= 1'b1;
      end else begin
        unique case (st)
          S_IDLE:
            if (wr_en && vpp_ok && addr[CMD_AW-1:0] == U1_A && wdata[7:0] == U1_D)
              st <= S_UNLK1;
          S_UNLK1:
            if (wr_en)
              st <= (vpp_ok && addr[CMD_AW-1:0] == U2_A && wdata[7:0] == U2_D) ? S_UNLK2 : S_IDLE;
          S_UNLK2:
            if (wr_en) begin
              if (vpp_ok && addr[CMD_AW-1:0] == U1_A && wdata[7:0] == GO_D) begin
                st     <= S_P_FIRST;
                err_q  <= 1'b0;
                verr_q <= 1'b0;
                tgl_q  <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end
          S_P_FIRST:
            if (wr_en) begin
              mark_q <= addr[ADDR_W-1:MARK_LO];
              idx_q  <= addr[IDX_W-1:0];
              wbuf   <= wdata;
              cnt    <= CNT_W'(PROG_CYC - 1);
              st     <= S_P_BUSY;
            end
          S_P_BUSY:
            if (cnt == '0) begin
              mem[idx_q] <= mem[idx_q] & wbuf;
              idx_q      <= idx_q + 1'b1;
              st         <= S_P_RUN;
            end else begin
              cnt <= cnt - 1'b1;
            end
          S_P_RUN:
            if (wr_en) begin
              if (cont) begin
                wbuf <= wdata;
                cnt  <= CNT_W'(PROG_CYC - 1);
                st   <= S_P_BUSY;
              end else begin
                st <= S_V_FIRST;
              end
            end
          S_V_FIRST:
            if (wr_en) begin
              mark_q <= addr[ADDR_W-1:MARK_LO];
              idx_q  <= addr[IDX_W-1:0];
              wbuf   <= wdata;
              cnt    <= '0;
              tries  <= '0;
              st     <= S_V_BUSY;
            end
          S_V_BUSY:
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else if (mem[idx_q] == wbuf) begin
              idx_q <= idx_q + 1'b1;
              st    <= S_V_RUN;
            end else if (tries == TRY_W'(MAX_RETRY)) begin
              err_q <= 1'b1;
              st    <= S_FAIL;
            end else begin
              mem[idx_q] <= mem[idx_q] & wbuf;
              tries      <= tries + 1'b1;
              cnt        <= CNT_W'(PROG_CYC - 1);
            end
          S_V_RUN:
            if (wr_en) begin
              if (cont) begin
                wbuf  <= wdata;
                cnt   <= '0;
                tries <= '0;
                st    <= S_V_BUSY;
              end else begin
                tgl_q <= 1'b0;
                st    <= S_IDLE;
              end
            end
          S_FAIL:
            if (wr_en && vpp_ok && wdata[7:0] == CLR_D) begin
              err_q  <= 1'b0;
              verr_q <= 1'b0;
              tgl_q  <= 1'b0;
              st     <= S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/burst_prog_seq_chk.sv
module burst_prog_seq_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic             vpp_ok,
  input logic             in_op,
  input logic             run_st,
  input logic             fail_st,
  input logic             err_q,
  input logic             verr_q,
  input logic             tgl_q,
  input logic [IDX_W-1:0] idx_q
);
  // R9
  vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_op && !fail_st && !vpp_ok |=> err_q && verr_q);

  // R9
  vpp_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verr_q |-> err_q);

  // R8
  err_only_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> in_op);

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_st && vpp_ok |=> $stable(idx_q));

  // R11
  fail_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_st && rd_en && !wr_en |=> tgl_q != $past(tgl_q));
endmodule

bind burst_prog_seq burst_prog_seq_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .vpp_ok(vpp_ok),
  .in_op(in_op), .run_st(run_st), .fail_st(fail_st), .err_q(err_q),
  .verr_q(verr_q), .tgl_q(tgl_q), .idx_q(idx_q)
);

// File: tb/burst_prog_seq_tb.sv
module burst_prog_seq_tb_top;
  localparam int AW = 22, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, vpp_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit exp_tgl = 1'b0;

  logic [DW-1:0] q_exp[$];
  logic [DW-1:0] q_msk[$];
  string         q_req[$];

  always #2 clk = ~clk;

  burst_prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok), .rdata(rdata)
  );

  function automatic logic [AW-1:0] mk(input logic [4:0] mark, input logic [16:0] low);
    return {mark, low};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup();
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h00C7);
    exp_tgl = 1'b0;
  endtask

  task automatic rd_arr(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    q_exp.push_back(e); q_msk.push_back(16'hFFFF); q_req.push_back(req);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_stat(input logic [DW-1:0] msk, input logic [DW-1:0] e, input string req);
    q_exp.push_back((e & ~16'h0040) | (16'(exp_tgl) << 6));
    q_msk.push_back(msk | 16'h0040);
    q_req.push_back(req);
    exp_tgl = ~exp_tgl;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (q_exp.size() == 0) begin
          errors++;
          $display("FAIL unexpected read: actual %h expected none", rdata);
        end else begin
          automatic logic [DW-1:0] e = q_exp.pop_front();
          automatic logic [DW-1:0] m = q_msk.pop_front();
          automatic string r = q_req.pop_front();
          checks++;
          if ((rdata & m) != (e & m)) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (mask %h)", r, rdata & m, e & m, m);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2 reset state
    rd_arr(22'h000, 16'hFFFF, "R2 erased word after reset");
    rd_arr(22'h0FF, 16'hFFFF, "R2 erased top word");

    // R1 wrong third write leaves read mode
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h0000);
    rd_arr(22'h005, 16'hFFFF, "R1 bad setup stays in read mode");

    // R1 good setup, R11 toggle
    setup();
    rd_stat(16'h00B1, 16'h0080, "R1 started, ready");
    rd_stat(16'h00B1, 16'h0080, "R11 toggle flips");

    // Program pass: start mark 3, index 0x10
    wr(mk(5'd3, 17'h00010), 16'h1234);
    rd_stat(16'h0001, 16'h0001, "R6 busy after word");
    wr(mk(5'd3, 17'h00011), 16'h0000); // R6 dropped while busy
    idle(12);
    wr(mk(5'd3, 17'h1ABCD), 16'h5678); // R3 low bits ignored
    idle(12);
    wr(mk(5'd3, 17'h00000), 16'hFFF0);
    idle(12);
    wr(mk(5'd7, 17'h00010), 16'h0000); // R4 final, bit 19 differs
    rd_stat(16'h00B1, 16'h0080, "R4 final write ends program pass");

    // Verify pass
    wr(mk(5'd3, 17'h00010), 16'h1234);
    idle(12);
    wr(mk(5'd3, 17'h00000), 16'h5678);
    idle(12);
    wr(mk(5'd3, 17'h00000), 16'hFF00); // R7 mismatch, reprogram fixes
    idle(20);
    wr(mk(5'd2, 17'h00000), 16'h0000); // final
    idle(2);
    rd_arr(22'h010, 16'h1234, "R6 busy write dropped / R3 first word");
    rd_arr(22'h011, 16'h5678, "R3 consecutive index");
    rd_arr(22'h012, 16'hFF00, "R7 reprogrammed word / R5 AND");
    rd_arr(22'h013, 16'hFFFF, "R4 final data not written");

    // R8 reprogram failure
    setup();
    wr(mk(5'd0, 17'h00020), 16'h00FF);
    idle(12);
    wr(mk(5'd1, 17'h00020), 16'h0000); // bit 17 differs: final
    wr(mk(5'd0, 17'h00020), 16'hFFFF); // cannot set bits back
    idle(40);
    rd_stat(16'h00B1, 16'h00A0, "R8 failed with error");
    wr(22'h000, 16'h0012); // R10 ignored in failure
    rd_stat(16'h00B1, 16'h00A0, "R10 other write ignored / R11 toggles");
    wr(22'h000, 16'h00F0); // R10 clear
    rd_arr(22'h020, 16'h00FF, "R10 read mode restored / R5 bits stay 0");

    // R9 program-voltage loss
    setup();
    wr(mk(5'd0, 17'h00030), 16'h0F0F);
    vpp_ok = 1'b0;
    @(negedge clk);
    vpp_ok = 1'b1;
    idle(12);
    rd_stat(16'h00B1, 16'h00B0, "R9 voltage loss flags");
    wr(22'h000, 16'h00F0);
    rd_arr(22'h030, 16'hFFFF, "R9 interrupted word not written");

    idle(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule